// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked user port and a static RAM that has no clock of its own. The user raises a request for one cycle, giving an address, a direction and, for writes, a data word. The sequencer then drives the memory's address, chip enable, read/write line and write data through a fixed series of phases. Each phase lasts a whole number of clock cycles, and the timing figures of the memory set those numbers through parameters.

A write has three phases. First, the address and enable settle while the read/write line stays high. Next, the read/write line is held low while the data is driven. Last, the read/write line is raised again while the address and data are held. A read holds the address with the line high until the access time has passed, and then captures the memory's output. A one-cycle done pulse marks the end of every access. Busy stays high from acceptance until that pulse, and requests made while busy are dropped.

On the memory side, the read/write line is high for a read and low for a write. Every pin is driven straight from a flop, so no combinational glitch reaches the unclocked memory.

Top module: `sram_seq`

## Requirements
- R1: During and just after reset: busy=0, done=0, mem_en=0, mem_rw=1 (read level), mem_wdata_oe=0 and rd_data=0.
- R2: A request (req_valid=1) is taken only in a cycle where busy=0. A request seen while busy=1 changes no memory pin and produces no done pulse.
- R3: busy is 1 from the cycle after acceptance until the last phase cycle. done is a single-cycle pulse in the following cycle, with busy=0.
- R4: For a write (req_write=1), mem_en=1 and mem_addr holds the request address with mem_rw=1 for exactly T1_CYC cycles before mem_rw falls.
- R5: mem_rw=0 (write level) lasts exactly T2_CYC cycles. Throughout, mem_wdata_oe=1 and mem_wdata carries the request word unchanged.
- R6: After mem_rw rises, mem_en, mem_addr, mem_wdata and mem_wdata_oe=1 are held for exactly T3_CYC cycles. A write therefore keeps busy high for T1_CYC+T2_CYC+T3_CYC cycles.
- R7: For a read (req_write=0), mem_en=1 and mem_rw=1 with a steady mem_addr for exactly ACCESS_CYC cycles. mem_rdata is sampled at the end of the last of those cycles. rd_data shows it in the done cycle and keeps it until the next read completes.
- R8: Whenever busy=0, mem_en=0, mem_rw=1 and mem_wdata_oe=0. There is therefore at least one disabled cycle between accesses, even when a new request is given in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read word |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_en | output | 1 | Memory enable |
| mem_rw | output | 1 | Memory read/write, 1 = read, 0 = write |
| mem_wdata | output | DATA_W | Data toward the memory |
| mem_wdata_oe | output | 1 | Drive enable for mem_wdata |
| mem_rdata | input | DATA_W | Data from the memory |

## Verification
The assertions assume that the memory holds mem_rdata valid once ACCESS_CYC cycles of steady address have passed. They also assume that reset is released away from a clock edge. The bench memory model provides the first: it returns the inverted word whenever fewer cycles of steady enabled read have elapsed, so an early sample shows up as wrong data. Requests are driven on falling edges and held for one cycle. Some are deliberately placed while busy, and some in the done cycle, to reach both the ignore rule and back-to-back operation.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_W_SETUP,
        PH_W_PULSE,
        PH_W_HOLD,
        PH_R_ACCESS
    } phase_e;

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign zero = (tmr_q.cnt == '0);

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !zero |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1)); // R3

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_nxt,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en,
    output logic              mem_rw,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              en;
        logic              rw;
        logic              oe;
    } pins_t;

    pins_t pins_d, pins_q;

    always_comb begin
        pins_d = pins_q;
        if (load) begin
            pins_d.addr  = addr_in;
            pins_d.wdata = wdata_in;
        end
        pins_d.en = (phase_nxt != PH_IDLE);
        pins_d.rw = (phase_nxt != PH_W_PULSE);
        pins_d.oe = (phase_nxt == PH_W_PULSE) || (phase_nxt == PH_W_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q      <= '0;
            pins_q.rw   <= 1'b1;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign mem_addr     = pins_q.addr;
    assign mem_wdata    = pins_q.wdata;
    assign mem_en       = pins_q.en;
    assign mem_rw       = pins_q.rw;
    assign mem_wdata_oe = pins_q.oe;

    AST_RW_LOW_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rw |-> mem_wdata_oe && mem_en); // R5
    AST_ADDR_HELD_WHILE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_en) && mem_en |-> $stable(mem_addr)); // R6
    AST_DATA_HELD_WHILE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_wdata_oe) && mem_wdata_oe |-> $stable(mem_wdata)); // R5
    AST_RW_RISE_KEEPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rw) && mem_en |-> mem_wdata_oe); // R6

endmodule

// File: rtl/sram_seq_rdcap.sv
module sram_seq_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (capture) cap_d.word = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign dout = cap_q.word;

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int T1_CYC     = 2,
    parameter int T2_CYC     = 3,
    parameter int T3_CYC     = 1,
    parameter int ACCESS_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en,
    output logic              mem_rw,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int MAX_T = max_of4(T1_CYC, T2_CYC, T3_CYC, ACCESS_CYC);
    localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;
    localparam logic [CNT_W-1:0] LD_T1  = CNT_W'(T1_CYC - 1);
    localparam logic [CNT_W-1:0] LD_T2  = CNT_W'(T2_CYC - 1);
    localparam logic [CNT_W-1:0] LD_T3  = CNT_W'(T3_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(ACCESS_CYC - 1);

    typedef struct packed {
        phase_e phase;
        logic   done;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             capture;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        seq_d.phase = PH_W_SETUP;
                        tmr_val     = LD_T1;
                    end else begin
                        seq_d.phase = PH_R_ACCESS;
                        tmr_val     = LD_ACC;
                    end
                end
            end
            PH_W_SETUP: begin
                if (tmr_zero) begin
                    seq_d.phase = PH_W_PULSE;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_T2;
                end
            end
            PH_W_PULSE: begin
                if (tmr_zero) begin
                    seq_d.phase = PH_W_HOLD;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_T3;
                end
            end
            PH_W_HOLD: begin
                if (tmr_zero) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            PH_R_ACCESS: begin
                if (tmr_zero) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                    capture     = 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.phase != PH_IDLE);
    assign done = seq_q.done;

    sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_nxt    (seq_d.phase),
        .load         (accept),
        .addr_in      (req_addr),
        .wdata_in     (req_wdata),
        .mem_addr     (mem_addr),
        .mem_en       (mem_en),
        .mem_rw       (mem_rw),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe)
    );

    sram_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (mem_rdata),
        .dout    (rd_data)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3
    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_valid |=> $stable(mem_addr) && $stable(mem_wdata)); // R2
    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en && mem_rw && !mem_wdata_oe); // R8
    AST_RDDATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done); // R7
    AST_EN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_en); // R4

endmodule

// File: tb/sram_seq_test.sv
module sram_seq_test;

    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int T1  = 2;
    localparam int T2  = 3;
    localparam int T3  = 1;
    localparam int ACC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_en, mem_rw, mem_wdata_oe;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    sram_seq #(.ADDR_W(AW), .DATA_W(DW), .T1_CYC(T1), .T2_CYC(T2),
               .T3_CYC(T3), .ACCESS_CYC(ACC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_en(mem_en), .mem_rw(mem_rw),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] mem_arr [256];
    logic [DW-1:0] ref_mem [256];
    int            stab = 0;
    int            low_cnt = 0;
    int            hold_cnt = 0;
    bit            in_hold = 0;
    logic [AW-1:0] hold_addr = '0;
    logic [DW-1:0] wlatch = '0;
    logic          prev_en = 1'b0;
    logic          prev_rw = 1'b1;
    logic [AW-1:0] prev_addr = '0;

    assign mem_rdata = (stab >= ACC) ? mem_arr[mem_addr] : ~mem_arr[mem_addr];

    // ---------------- reference sequence ----------------
    typedef struct {
        bit            busy, done, en, rw, oe, rdv;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd, rd;
        string         tag;
    } ent_t;

    ent_t          exp_q [$];
    bit            cur_busy = 0;
    logic [DW-1:0] exp_rd = '0;
    int            accepted = 0;
    int            dones_seen = 0;

    function automatic ent_t mk(bit b, bit d, bit en, bit rw, bit oe, bit rdv,
                                logic [AW-1:0] a, logic [DW-1:0] wd,
                                logic [DW-1:0] rd, string tag);
        ent_t e;
        e.busy = b; e.done = d; e.en = en; e.rw = rw; e.oe = oe; e.rdv = rdv;
        e.addr = a; e.wd = wd; e.rd = rd; e.tag = tag;
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst_n && !cur_busy && req_valid) begin
            accepted++;
            if (req_write) begin
                ref_mem[req_addr] = req_wdata;
                for (int i = 0; i < T1; i++)
                    exp_q.push_back(mk(1, 0, 1, 1, 0, 0, req_addr, req_wdata, '0, "R4"));
                for (int i = 0; i < T2; i++)
                    exp_q.push_back(mk(1, 0, 1, 0, 1, 0, req_addr, req_wdata, '0, "R5"));
                for (int i = 0; i < T3; i++)
                    exp_q.push_back(mk(1, 0, 1, 1, 1, 0, req_addr, req_wdata, '0, "R6"));
                exp_q.push_back(mk(0, 1, 0, 1, 0, 0, req_addr, req_wdata, '0, "R6"));
            end else begin
                for (int i = 0; i < ACC; i++)
                    exp_q.push_back(mk(1, 0, 1, 1, 0, 0, req_addr, '0, '0, "R7"));
                exp_q.push_back(mk(0, 1, 0, 1, 0, 1, req_addr, '0, ref_mem[req_addr], "R7"));
            end
        end
    end

    always @(negedge clk) begin
        ent_t e;
        if (!rst_n) begin
            cur_busy = 0;
        end else begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else e = mk(0, 0, 0, 1, 0, 0, '0, '0, '0, "R8");
            cur_busy = e.busy;
            if (e.rdv) exp_rd = e.rd;
            if (done) dones_seen++;
            chk(busy === e.busy, {e.tag, " R3 busy"}, 32'(busy), 32'(e.busy));
            chk(done === e.done, {e.tag, " R3 done"}, 32'(done), 32'(e.done));
            chk(mem_en === e.en, {e.tag, " mem_en"}, 32'(mem_en), 32'(e.en));
            chk(mem_rw === e.rw, {e.tag, " mem_rw"}, 32'(mem_rw), 32'(e.rw));
            chk(mem_wdata_oe === e.oe, {e.tag, " mem_wdata_oe"}, 32'(mem_wdata_oe), 32'(e.oe));
            if (e.en) chk(mem_addr === e.addr, {e.tag, " mem_addr"}, 32'(mem_addr), 32'(e.addr));
            if (e.oe) chk(mem_wdata === e.wd, {e.tag, " mem_wdata"}, 32'(mem_wdata), 32'(e.wd));
            chk(rd_data === exp_rd, "R7 rd_data", 32'(rd_data), 32'(exp_rd));

            // memory-side timing checks
            if (prev_rw && !mem_rw)
                chk(stab >= T1, "R4 t1 setup", 32'(stab), 32'(T1));
            if (!mem_rw) begin
                if (low_cnt == 0) wlatch = mem_wdata;
                else chk(mem_wdata === wlatch, "R5 data steady", 32'(mem_wdata), 32'(wlatch));
                low_cnt++;
            end
            if (!prev_rw && mem_rw) begin
                chk(low_cnt >= T2, "R5 t2 pulse", 32'(low_cnt), 32'(T2));
                mem_arr[mem_addr] = wlatch;
                in_hold   = 1;
                hold_cnt  = 1;
                hold_addr = mem_addr;
                low_cnt   = 0;
            end else if (in_hold) begin
                if (mem_en && mem_addr == hold_addr && mem_wdata_oe) hold_cnt++;
                else begin
                    chk(hold_cnt >= T3, "R6 t3 hold", 32'(hold_cnt), 32'(T3));
                    in_hold = 0;
                end
            end
            if (mem_en && mem_rw && prev_en && prev_rw && mem_addr == prev_addr) stab++;
            else if (mem_en && mem_rw) stab = 1;
            else stab = 0;
            prev_en   = mem_en;
            prev_rw   = mem_rw;
            prev_addr = mem_addr;
        end
    end

    // ---------------- stimulus ----------------
    int issued = 0;

    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = DW'(i * 16'h0101) ^ 16'h5a5a;
            ref_mem[i] = mem_arr[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done", {busy, done}, 0);
        chk(mem_en === 1'b0 && mem_rw === 1'b1 && mem_wdata_oe === 1'b0, "R1 pins",
            {mem_en, mem_rw, mem_wdata_oe}, 3'b010);
        chk(rd_data === '0, "R1 rd_data", 32'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && mem_en === 1'b0, "R1 after release", {busy, mem_en}, 0);

        issue(1, 8'h10, 16'hBEEF);   // R4 R5 R6
        issue(0, 8'h10, 16'h0000);   // R7 read back
        issue(0, 8'h22, 16'h0000);   // R7 untouched word
        issue(1, 8'hFF, 16'hFFFF);
        issue(0, 8'hFF, 16'h0000);
        issue(1, 8'h00, 16'h0000);
        issue(0, 8'h00, 16'h1234);

        // R2: requests while busy are dropped
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h40; req_wdata = 16'hA5A5;
        issued++;
        @(negedge clk);
        req_addr = 8'h41; req_wdata = 16'h5A5A; req_write = 1'b0;
        @(negedge clk);
        req_addr = 8'h42;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        issue(0, 8'h41, 16'h0000);   // R2: 0x41 still holds its old word
        issue(0, 8'h40, 16'h0000);

        // back-to-back traffic, R8 gap checked by reference entries
        for (int k = 0; k < 30; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 15));
            issue(1'($urandom_range(0, 1)), a, DW'($urandom));
        end
        repeat (3) @(negedge clk);
        chk(dones_seen == issued, "R2 done count", 32'(dones_seen), 32'(issued));
        chk(accepted == issued, "R2 accept count", 32'(accepted), 32'(issued));
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R3 actual=%h expected=%h", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule